// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a device-side I/O virtual address into a physical address. It walks a two-level table held in memory. The upper bits of the address pick one of up to four root tables. The next field indexes a first-level directory whose entry points at a leaf table. The field below that indexes the leaf entry, which holds the page frame and its access restrictions. Each walk issues two 64-bit reads, one after the other, through a plain read port that uses a valid/ready request and a one-beat data return.

Configuration selects one of two entry layouts and one of two page granules, 4 KiB or 16 KiB. It also sets how many root tables are live and gives their base addresses. In the older layout the frame sits in the entry unshifted. In the newer layout the frame is stored shifted right by four bits. Each layout places its read-deny and write-deny flags at different bits.

A walk ends with a registered result: either the translated address with a non-cacheable flag, or a fault with a two-bit cause. The walker takes one request at a time and holds the result until the requester takes it.

Top module: `iopt_walker`

## Requirements
- R1: The table select value is every input address bit from bit 3*b+3 upward, where b is the bits per level (b=11 for 16 KiB, b=9 for 4 KiB), so selection starts at bit 36 or bit 30. If this value is not below min(cfg_num_tables, NUM_ROOTS), the response carries cause 1 (bad table) and no memory read is issued.
- R2: The first memory read goes to the selected root base plus 8 times the first-level index. That index is address bits 35:25 with 16 KiB pages and bits 29:21 with 4 KiB pages.
- R3: After the first-level data returns, the second read goes to the table base decoded from that entry plus 8 times the leaf index. The leaf index is address bits 24:14 with 16 KiB pages and bits 20:12 with 4 KiB pages.
- R4: Decoding when cfg_fmt_new=0: entry bits 35:12 become physical bits 35:12. Decoding when cfg_fmt_new=1: entry bits 37:10 become physical bits 41:14. The same rule applies to first-level and leaf entries.
- R5: A first-level entry equal to zero ends the walk with cause 2 (not mapped) after exactly one read. Any nonzero first-level entry is taken as a table pointer.
- R6: A leaf entry with bit 0 clear ends the walk with cause 2. This check takes precedence over any permission result for the same entry.
- R7: In the older layout, leaf bit 8 denies reads and leaf bit 7 denies writes. A denied access gives cause 3 (permission). Leaf bits 3:1 have no effect, and rsp_nocache is 0.
- R8: In the newer layout, leaf bit 3 denies reads and leaf bit 2 denies writes, giving cause 3. Leaf bit 1 sets rsp_nocache. Leaf bits 8:7 have no effect.
- R9: On success, rsp_fault=0, rsp_cause=0, and rsp_paddr equals the decoded leaf address ORed with the in-page offset. The offset is address bits 13:0 with 16 KiB pages and bits 11:0 with 4 KiB pages.
- R10: A response stays valid and unchanged until rsp_ready is seen. req_ready is low from request acceptance until the response is taken. A memory read request stays valid at a fixed address until mem_rd_ready is seen.
- R11: After reset, req_ready=1, rsp_valid=0 and mem_rd_valid=0.
- R12: Any fault response has rsp_fault=1, rsp_paddr=0 and rsp_nocache=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt_new | input | 1 | 0: older entry layout, 1: newer shifted layout |
| cfg_gran_16k | input | 1 | 1: 16 KiB pages, 0: 4 KiB pages |
| cfg_num_tables | input | 3 | Number of live root tables |
| cfg_root_base | input | 168 | Root table base addresses, table k at bits k*42 upward |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 42 | I/O virtual address |
| req_write | input | 1 | 1: write access, 0: read access |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_addr | output | 42 | Byte address of the 64-bit entry |
| mem_data_valid | input | 1 | Read data valid |
| mem_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 bad table, 2 not mapped, 3 permission |
| rsp_paddr | output | 42 | Translated physical address |
| rsp_nocache | output | 1 | Page marked non-cacheable |

## Verification
Two checks act on the same leaf word in the same cycle: the validity test and the permission test. The bench provokes a collision with a leaf that has bit 0 clear but both deny bits set, then issues a read to it; the result must be cause 2, not cause 3. The bench also collides response holding with new traffic. It withholds rsp_ready for a varying number of cycles, requires the result to stay frozen and req_ready to stay low, and only then lets the next request in.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int ENT_W       = 64;
  localparam int ENT_SH      = 3;
  localparam int SMALL_PG_SH = 12;
  localparam int LARGE_PG_SH = 14;

  localparam int OLD_PA_HI = 35;
  localparam int OLD_PA_LO = 12;
  localparam int NEW_PA_HI = 37;
  localparam int NEW_PA_LO = 10;
  localparam int NEW_PA_SH = 4;

  localparam int OLD_NO_RD = 8;
  localparam int OLD_NO_WR = 7;
  localparam int NEW_NO_RD = 3;
  localparam int NEW_NO_WR = 2;
  localparam int NEW_NO_CA = 1;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_BAD_TABLE = 2'd1,
    FLT_UNMAPPED  = 2'd2,
    FLT_PERM      = 2'd3
  } flt_cause_e;

  typedef enum logic [2:0] {
    W_IDLE, W_RD1, W_WT1, W_RD2, W_WT2, W_RSP
  } walk_st_e;
endpackage

// File: rtl/iopt_index.sv
module iopt_index
  import iopt_pkg::*;
#(
  parameter int IN_AW = 42,
  parameter int LVL_W = LARGE_PG_SH - ENT_SH,
  parameter int OFF_W = LARGE_PG_SH
) (
  input  logic [IN_AW-1:0] va,
  input  logic             gran_large,
  output logic [LVL_W-1:0] l1_idx,
  output logic [LVL_W-1:0] l2_idx,
  output logic [IN_AW-1:0] tbl_sel,
  output logic [OFF_W-1:0] pg_off
);
  localparam int BPL_S = SMALL_PG_SH - ENT_SH;
  localparam int BPL_L = LARGE_PG_SH - ENT_SH;

  function automatic logic [IN_AW-1:0] slice_up(input logic [IN_AW-1:0] v,
                                                input int sh, input int w);
    logic [IN_AW-1:0] m;
    m = (IN_AW'(1) << w) - IN_AW'(1);
    return (v >> sh) & m;
  endfunction

  always_comb begin
    if (gran_large) begin
      l2_idx  = LVL_W'(slice_up(va, BPL_L + ENT_SH, BPL_L));
      l1_idx  = LVL_W'(slice_up(va, 2 * BPL_L + ENT_SH, BPL_L));
      tbl_sel = va >> (3 * BPL_L + ENT_SH);
      pg_off  = OFF_W'(slice_up(va, 0, LARGE_PG_SH));
    end else begin
      l2_idx  = LVL_W'(slice_up(va, BPL_S + ENT_SH, BPL_S));
      l1_idx  = LVL_W'(slice_up(va, 2 * BPL_S + ENT_SH, BPL_S));
      tbl_sel = va >> (3 * BPL_S + ENT_SH);
      pg_off  = OFF_W'(slice_up(va, 0, SMALL_PG_SH));
    end
  end
endmodule

// File: rtl/iopt_entry_dec.sv
module iopt_entry_dec
  import iopt_pkg::*;
#(
  parameter int PA_W = 42
) (
  input  logic [ENT_W-1:0] ent,
  input  logic             fmt_new,
  output logic [PA_W-1:0]  pa,
  output logic             is_zero,
  output logic             vld,
  output logic             no_rd,
  output logic             no_wr,
  output logic             no_cache
);
  localparam int OLD_W = OLD_PA_HI - OLD_PA_LO + 1;
  localparam int NEW_W = NEW_PA_HI - NEW_PA_LO + 1;

  logic [OLD_W-1:0] old_fld;
  logic [NEW_W-1:0] new_fld;

  assign old_fld = ent[OLD_PA_HI:OLD_PA_LO];
  assign new_fld = ent[NEW_PA_HI:NEW_PA_LO];
  assign is_zero = (ent == '0);
  assign vld     = ent[0];

  always_comb begin
    if (fmt_new) begin
      pa       = PA_W'(new_fld) << (NEW_PA_LO + NEW_PA_SH);
      no_rd    = ent[NEW_NO_RD];
      no_wr    = ent[NEW_NO_WR];
      no_cache = ent[NEW_NO_CA];
    end else begin
      pa       = PA_W'(old_fld) << OLD_PA_LO;
      no_rd    = ent[OLD_NO_RD];
      no_wr    = ent[OLD_NO_WR];
      no_cache = 1'b0;
    end
  end
endmodule

// File: rtl/iopt_perm.sv
module iopt_perm (
  input  logic is_write,
  input  logic no_rd,
  input  logic no_wr,
  output logic deny
);
  assign deny = is_write ? no_wr : no_rd;
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int IN_AW     = 42,
  parameter int PA_W      = 42,
  parameter int NUM_ROOTS = 4,
  localparam int TCW   = $clog2(NUM_ROOTS + 1),
  localparam int SELW  = (NUM_ROOTS > 1) ? $clog2(NUM_ROOTS) : 1,
  localparam int LVL_W = LARGE_PG_SH - ENT_SH,
  localparam int OFF_W = LARGE_PG_SH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_fmt_new,
  input  logic                      cfg_gran_16k,
  input  logic [TCW-1:0]            cfg_num_tables,
  input  logic [NUM_ROOTS*PA_W-1:0] cfg_root_base,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [IN_AW-1:0]          req_addr,
  input  logic                      req_write,
  output logic                      mem_rd_valid,
  input  logic                      mem_rd_ready,
  output logic [PA_W-1:0]           mem_rd_addr,
  input  logic                      mem_data_valid,
  input  logic [ENT_W-1:0]          mem_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_cause,
  output logic [PA_W-1:0]           rsp_paddr,
  output logic                      rsp_nocache
);
  walk_st_e         state;
  logic [IN_AW-1:0] va_q;
  logic             wr_q;

  logic [PA_W-1:0] root_tbl [NUM_ROOTS];
  for (genvar g = 0; g < NUM_ROOTS; g++) begin : g_root
    assign root_tbl[g] = cfg_root_base[g*PA_W +: PA_W];
  end

  logic [IN_AW-1:0] idx_va;
  logic [LVL_W-1:0] l1_idx, l2_idx;
  logic [IN_AW-1:0] tbl_sel;
  logic [OFF_W-1:0] pg_off;

  assign idx_va = (state == W_IDLE) ? req_addr : va_q;

  iopt_index #(.IN_AW(IN_AW), .LVL_W(LVL_W), .OFF_W(OFF_W)) u_index (
    .va(idx_va), .gran_large(cfg_gran_16k),
    .l1_idx(l1_idx), .l2_idx(l2_idx), .tbl_sel(tbl_sel), .pg_off(pg_off)
  );

  logic [TCW-1:0]  tbl_lim;
  logic            tbl_bad;
  logic [SELW-1:0] sel_idx;
  logic [PA_W-1:0] l1_addr, l2_addr;

  assign tbl_lim = (cfg_num_tables > TCW'(NUM_ROOTS)) ? TCW'(NUM_ROOTS) : cfg_num_tables;
  assign tbl_bad = (tbl_sel >= IN_AW'(tbl_lim));
  assign sel_idx = tbl_sel[SELW-1:0];
  assign l1_addr = root_tbl[sel_idx] + (PA_W'(l1_idx) << ENT_SH);

  logic [PA_W-1:0] dec_pa;
  logic dec_zero, dec_vld, dec_no_rd, dec_no_wr, dec_nc, deny;

  iopt_entry_dec #(.PA_W(PA_W)) u_dec (
    .ent(mem_data), .fmt_new(cfg_fmt_new), .pa(dec_pa), .is_zero(dec_zero),
    .vld(dec_vld), .no_rd(dec_no_rd), .no_wr(dec_no_wr), .no_cache(dec_nc)
  );

  assign l2_addr = dec_pa + (PA_W'(l2_idx) << ENT_SH);

  iopt_perm u_perm (
    .is_write(wr_q), .no_rd(dec_no_rd), .no_wr(dec_no_wr), .deny(deny)
  );

  assign req_ready = (state == W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= W_IDLE;
      va_q         <= '0;
      wr_q         <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_cause    <= FLT_NONE;
      rsp_paddr    <= '0;
      rsp_nocache  <= 1'b0;
    end else begin
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            va_q <= req_addr;
            wr_q <= req_write;
            if (tbl_bad) begin
              rsp_valid   <= 1'b1;
              rsp_fault   <= 1'b1;
              rsp_cause   <= FLT_BAD_TABLE;
              rsp_paddr   <= '0;
              rsp_nocache <= 1'b0;
              state       <= W_RSP;
            end else begin
              mem_rd_valid <= 1'b1;
              mem_rd_addr  <= l1_addr;
              state        <= W_RD1;
            end
          end
        end
        W_RD1: begin
          if (mem_rd_ready) begin
            mem_rd_valid <= 1'b0;
            state        <= W_WT1;
          end
        end
        W_WT1: begin
          if (mem_data_valid) begin
            if (dec_zero) begin
              rsp_valid   <= 1'b1;
              rsp_fault   <= 1'b1;
              rsp_cause   <= FLT_UNMAPPED;
              rsp_paddr   <= '0;
              rsp_nocache <= 1'b0;
              state       <= W_RSP;
            end else begin
              mem_rd_valid <= 1'b1;
              mem_rd_addr  <= l2_addr;
              state        <= W_RD2;
            end
          end
        end
        W_RD2: begin
          if (mem_rd_ready) begin
            mem_rd_valid <= 1'b0;
            state        <= W_WT2;
          end
        end
        W_WT2: begin
          if (mem_data_valid) begin
            rsp_valid <= 1'b1;
            state     <= W_RSP;
            if (!dec_vld || deny) begin
              rsp_fault   <= 1'b1;
              rsp_cause   <= !dec_vld ? FLT_UNMAPPED : FLT_PERM;
              rsp_paddr   <= '0;
              rsp_nocache <= 1'b0;
            end else begin
              rsp_fault   <= 1'b0;
              rsp_cause   <= FLT_NONE;
              rsp_paddr   <= dec_pa | PA_W'(pg_off);
              rsp_nocache <= dec_nc;
            end
          end
        end
        W_RSP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R10: result frozen while the requester stalls
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_cause) && $stable(rsp_nocache)));

  // R10: memory request held until accepted
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R10: no new request accepted while a walk or result is pending
  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_rd_valid) |-> !req_ready);

  // R1: an out-of-range table select answers directly without a read
  assert_bad_table_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && tbl_bad) |=>
      (rsp_valid && rsp_cause == FLT_BAD_TABLE && !mem_rd_valid));

  // R12: fault results carry no address
  assert_fault_clean_R12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_nocache));
endmodule

// File: tb/test_iopt_walker.sv
module test_iopt_walker;
  logic clk = 1'b0;
  logic rst;
  logic cfg_fmt_new, cfg_gran_16k;
  logic [2:0] cfg_num_tables;
  logic [167:0] cfg_root_base;
  logic req_valid, req_ready, req_write;
  logic [41:0] req_addr;
  logic mem_rd_valid, mem_rd_ready;
  logic [41:0] mem_rd_addr;
  logic mem_data_valid;
  logic [63:0] mem_data;
  logic rsp_valid, rsp_ready, rsp_fault, rsp_nocache;
  logic [1:0] rsp_cause;
  logic [41:0] rsp_paddr;

  always #4 clk = ~clk;

  iopt_walker i_iopt_walker (
    .clk(clk), .rst(rst), .cfg_fmt_new(cfg_fmt_new), .cfg_gran_16k(cfg_gran_16k),
    .cfg_num_tables(cfg_num_tables), .cfg_root_base(cfg_root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_data_valid(mem_data_valid), .mem_data(mem_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache)
  );

  typedef struct packed { logic [1:0] cause; logic [41:0] pa; logic nc; } exp_t;
  exp_t        exp_q[$];
  string       tag_q[$];
  logic [41:0] addr_q[$];
  logic [63:0] mem_img [logic [41:0]];

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s", rq, what);
    end
  endtask

  function automatic logic [41:0] root(input int k);
    return 42'h10_0000 * (k + 1);
  endfunction
  function automatic logic [41:0] mk16(input int t, input int a, input int b, input int o);
    return (42'(t) << 36) | (42'(a) << 25) | (42'(b) << 14) | 42'(o);
  endfunction
  function automatic logic [41:0] mk4(input int t, input int a, input int b, input int o);
    return (42'(t) << 30) | (42'(a) << 21) | (42'(b) << 12) | 42'(o);
  endfunction
  function automatic logic [63:0] tbl_ent(input logic [41:0] b, input logic nf);
    if (nf) return {26'd0, b[41:14], 10'd1};
    return {28'd0, b[35:12], 12'd1};
  endfunction
  function automatic logic [63:0] leaf_ent(input logic [41:0] b, input logic nf,
      input logic v, input logic nr, input logic nw, input logic nc, input logic [63:0] extra);
    logic [63:0] e;
    e = tbl_ent(b, nf);
    e[0] = v;
    if (nf) begin
      e[3] = nr; e[2] = nw; e[1] = nc;
    end else begin
      e[8] = nr; e[7] = nw; e[1] = 1'b1; e[51:40] = 12'hfff;
    end
    return e | extra;
  endfunction

  task automatic put(input logic [41:0] a, input logic [63:0] d);
    mem_img[a] = d;
  endtask
  task automatic expect_rd(input logic [41:0] a);
    addr_q.push_back(a);
  endtask

  task automatic xlat(input logic [41:0] va, input logic wr, input logic [1:0] cause,
                      input logic [41:0] pa, input logic nc, input string rq);
    exp_t e;
    e.cause = cause; e.pa = pa; e.nc = nc;
    exp_q.push_back(e);
    tag_q.push_back(rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    chk(addr_q.size() == 0, rq,
        $sformatf("reads left unissued got %0d exp 0", addr_q.size()));
    addr_q.delete();
  endtask

  // memory model: stalls, checks read addresses, returns data one cycle later
  int stall = 0, stall_pat = 0;
  logic [41:0] lat_addr;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_data_valid) mem_data_valid = 1'b0;
      if (mem_rd_ready) begin
        mem_rd_ready = 1'b0;
        mem_data_valid = 1'b1;
        mem_data = mem_img.exists(lat_addr) ? mem_img[lat_addr] : 64'd0;
      end else if (mem_rd_valid) begin
        if (stall == 0) begin
          lat_addr = mem_rd_addr;
          if (addr_q.size() == 0)
            chk(1'b0, "R1/R5", $sformatf("unexpected read got %h exp none", mem_rd_addr));
          else begin
            logic [41:0] a;
            a = addr_q.pop_front();
            chk(mem_rd_addr == a, "R2/R3",
                $sformatf("read address got %h exp %h", mem_rd_addr, a));
          end
          mem_rd_ready = 1'b1;
          stall = stall_pat % 3;
          stall_pat++;
        end else stall--;
      end
    end
  end

  // response monitor / scoreboard
  bit seen = 0;
  int wait_n = 0, hold_pat = 0;
  logic [44:0] snap;
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_ready) begin
        rsp_ready = 1'b0;
        seen = 0;
      end else if (rsp_valid) begin
        chk(req_ready == 1'b0, "R10", $sformatf("req_ready while result pending got %0d exp 0", req_ready));
        if (!seen) begin
          snap = {rsp_cause, rsp_paddr, rsp_nocache};
          seen = 1;
          wait_n = hold_pat % 3;
          hold_pat++;
        end else
          chk({rsp_cause, rsp_paddr, rsp_nocache} == snap, "R10",
              $sformatf("held result changed got %h exp %h", {rsp_cause, rsp_paddr, rsp_nocache}, snap));
        if (wait_n == 0) begin
          if (exp_q.size() == 0)
            chk(1'b0, "R9", "unexpected response got one exp none");
          else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rsp_cause == e.cause && rsp_paddr == e.pa && rsp_nocache == e.nc &&
                rsp_fault == (e.cause != 2'd0), t,
                $sformatf("cause/pa/nc/fault got %0d/%h/%0d/%0d exp %0d/%h/%0d/%0d",
                          rsp_cause, rsp_paddr, rsp_nocache, rsp_fault,
                          e.cause, e.pa, e.nc, (e.cause != 2'd0)));
            if (e.cause != 2'd0)
              chk(rsp_fault && rsp_paddr == 42'd0 && !rsp_nocache, "R12",
                  $sformatf("fault fields got %0d/%h/%0d exp 1/0/0", rsp_fault, rsp_paddr, rsp_nocache));
          end
          rsp_ready = 1'b1;
        end else wait_n--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [41:0] l2a, l2b, l2c, l2d, l2e, pa;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    mem_rd_ready = 1'b0; mem_data_valid = 1'b0; mem_data = '0; rsp_ready = 1'b0;
    cfg_fmt_new = 1'b0; cfg_gran_16k = 1'b1; cfg_num_tables = 3'd4;
    cfg_root_base = {root(3), root(2), root(1), root(0)};
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R11",
        $sformatf("ready/rsp/rd got %0d/%0d/%0d exp 1/0/0", req_ready, rsp_valid, mem_rd_valid));

    // 16 KiB, older layout
    l2a = 42'h80_0000;
    pa  = 42'hF_ABCD_C000;
    put(root(1) + 3 * 8, tbl_ent(l2a, 1'b0));
    put(l2a + 5 * 8, leaf_ent(pa, 0, 1, 0, 0, 0, 64'd0));
    put(l2a + 6 * 8, leaf_ent(pa + 42'h4000, 0, 1, 0, 1, 0, 64'd0));
    put(l2a + 7 * 8, leaf_ent(pa + 42'h8000, 0, 1, 1, 0, 0, 64'd0));
    put(l2a + 8 * 8, leaf_ent(pa + 42'hC000, 0, 1, 0, 0, 0, 64'hE));
    put(l2a + 10 * 8, leaf_ent(pa, 0, 0, 1, 1, 0, 64'd0));

    expect_rd(root(1) + 24); expect_rd(l2a + 40);
    xlat(mk16(1, 3, 5, 'h123), 0, 2'd0, pa | 42'h123, 0, "R2/R4/R9 16k old read");
    expect_rd(root(1) + 24); expect_rd(l2a + 40);
    xlat(mk16(1, 3, 5, 'h3FFF), 1, 2'd0, pa | 42'h3FFF, 0, "R3/R9 16k old write");
    expect_rd(root(1) + 24); expect_rd(l2a + 48);
    xlat(mk16(1, 3, 6, 0), 1, 2'd3, 0, 0, "R7 write denied");
    expect_rd(root(1) + 24); expect_rd(l2a + 48);
    xlat(mk16(1, 3, 6, 'h10), 0, 2'd0, (pa + 42'h4000) | 42'h10, 0, "R7 read allowed");
    expect_rd(root(1) + 24); expect_rd(l2a + 56);
    xlat(mk16(1, 3, 7, 0), 0, 2'd3, 0, 0, "R7 read denied");
    expect_rd(root(1) + 24); expect_rd(l2a + 56);
    xlat(mk16(1, 3, 7, 'h20), 1, 2'd0, (pa + 42'h8000) | 42'h20, 0, "R7 write allowed");
    expect_rd(root(1) + 24); expect_rd(l2a + 64);
    xlat(mk16(1, 3, 8, 'h1), 1, 2'd0, (pa + 42'hC000) | 42'h1, 0, "R7 bits 3:1 ignored");
    expect_rd(root(0) + 32);
    xlat(mk16(0, 4, 0, 0), 0, 2'd2, 0, 0, "R5 empty directory");
    expect_rd(root(1) + 24); expect_rd(l2a + 72);
    xlat(mk16(1, 3, 9, 0), 0, 2'd2, 0, 0, "R6 empty leaf");
    expect_rd(root(1) + 24); expect_rd(l2a + 80);
    xlat(mk16(1, 3, 10, 0), 0, 2'd2, 0, 0, "R6 invalid beats permission");

    // table select range
    cfg_num_tables = 3'd2;
    xlat(mk16(2, 0, 0, 0), 0, 2'd1, 0, 0, "R1 select beyond count");
    xlat(mk16(0, 0, 0, 0) | (42'd1 << 40), 0, 2'd1, 0, 0, "R1 high select bits");
    cfg_num_tables = 3'd4;
    expect_rd(root(3));
    xlat(mk16(3, 0, 0, 0), 0, 2'd2, 0, 0, "R1 last table in range");
    cfg_num_tables = 3'd7;
    xlat(mk16(4, 0, 0, 0), 0, 2'd1, 0, 0, "R1 count clamped");
    cfg_num_tables = 3'd4;

    // 16 KiB max indices
    l2e = 42'hB0_0000;
    put(root(0) + 2047 * 8, tbl_ent(l2e, 1'b0));
    put(l2e + 2047 * 8, leaf_ent(42'h1_2340_0000, 0, 1, 0, 0, 0, 64'd0));
    expect_rd(root(0) + 2047 * 8); expect_rd(l2e + 2047 * 8);
    xlat(mk16(0, 2047, 2047, 'h3FFF), 0, 2'd0, 42'h1_2340_3FFF, 0, "R2/R3 max indices");

    // 16 KiB, newer layout
    cfg_fmt_new = 1'b1;
    l2b = 42'h1_0000_0000;
    pa  = 42'h2A5_1234_C000;
    put(root(2) + 8, tbl_ent(l2b, 1'b1));
    put(l2b + 16, leaf_ent(pa, 1, 1, 0, 0, 1, 64'd0));
    put(l2b + 24, leaf_ent(pa, 1, 1, 0, 1, 0, 64'd0));
    put(l2b + 32, leaf_ent(pa, 1, 1, 1, 0, 0, 64'd0));
    put(l2b + 40, leaf_ent(pa, 1, 1, 0, 0, 0, 64'h180));
    expect_rd(root(2) + 8); expect_rd(l2b + 16);
    xlat(mk16(2, 1, 2, 'h3FFF), 0, 2'd0, pa | 42'h3FFF, 1, "R4/R8 new layout nocache");
    expect_rd(root(2) + 8); expect_rd(l2b + 24);
    xlat(mk16(2, 1, 3, 0), 1, 2'd3, 0, 0, "R8 write denied");
    expect_rd(root(2) + 8); expect_rd(l2b + 32);
    xlat(mk16(2, 1, 4, 0), 0, 2'd3, 0, 0, "R8 read denied");
    expect_rd(root(2) + 8); expect_rd(l2b + 40);
    xlat(mk16(2, 1, 5, 'h7), 1, 2'd0, pa | 42'h7, 0, "R8 bits 8:7 ignored");

    // 4 KiB, older layout
    cfg_fmt_new = 1'b0; cfg_gran_16k = 1'b0;
    l2c = 42'h90_0000;
    pa  = 42'h3_4567_8000;
    put(root(2) + 7 * 8, tbl_ent(l2c, 1'b0));
    put(l2c + 9 * 8, leaf_ent(pa, 0, 1, 0, 0, 0, 64'd0));
    put(root(0) + 511 * 8, tbl_ent(l2c + 42'h1000, 1'b0));
    put(l2c + 42'h1000 + 511 * 8, leaf_ent(42'h5_0000_1000, 0, 1, 0, 0, 0, 64'd0));
    expect_rd(root(2) + 56); expect_rd(l2c + 72);
    xlat(mk4(2, 7, 9, 'hABC), 0, 2'd0, pa | 42'hABC, 0, "R2/R3/R9 4k old");
    expect_rd(root(0) + 511 * 8); expect_rd(l2c + 42'h1000 + 511 * 8);
    xlat(mk4(0, 511, 511, 'hFFF), 1, 2'd0, 42'h5_0000_1FFF, 0, "R2/R9 4k max indices");
    cfg_num_tables = 3'd3;
    xlat(mk4(3, 0, 0, 0), 0, 2'd1, 0, 0, "R1 4k select from bit 30");
    cfg_num_tables = 3'd4;

    // 4 KiB, newer layout
    cfg_fmt_new = 1'b1;
    l2d = 42'hA0_0000;
    pa  = 42'h155_5555_C000;
    put(root(1) + 16, tbl_ent(l2d, 1'b1));
    put(l2d + 24, leaf_ent(pa, 1, 1, 0, 0, 0, 64'd0));
    expect_rd(root(1) + 16); expect_rd(l2d + 24);
    xlat(mk4(1, 2, 3, 'h5A5), 0, 2'd0, pa | 42'h5A5, 0, "R4/R9 4k new layout");

    repeat (4) @(negedge clk);
    chk(!rsp_valid && !mem_rd_valid && req_ready, "R10",
        $sformatf("idle at end got rsp %0d rd %0d rdy %0d exp 0/0/1", rsp_valid, mem_rd_valid, req_ready));
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule